// File: doc/BRIEF.md
# Two-Bit Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It holds a direct-mapped table of two-bit saturating counters and selects one entry from the low-order word-address bits of the branch PC. A front-end stage presents a PC on the lookup port and gets a taken/not-taken guess in the same cycle. When the branch resolves later, the back end presents its PC and the actual direction on the update port. That input moves the selected counter one step toward the observed outcome.

Each table entry is a small four-state machine. The states are strong-not-taken (`CTR_SNT`, 2'b00), weak-not-taken (`CTR_WNT`, 2'b01), weak-taken (`CTR_WT`, 2'b10) and strong-taken (`CTR_ST`, 2'b11). The transitions are:
- *step-up*: a taken outcome moves SNT to WNT, WNT to WT and WT to ST.
- *step-down*: a not-taken outcome moves ST to WT, WT to WNT and WNT to SNT.
- *hold-top*: ST stays ST on a taken outcome.
- *hold-bottom*: SNT stays SNT on a not-taken outcome.
- *idle*: without a qualifying update the state is kept.

A compiler hint can mark a branch as likely taken. Such a branch is predicted taken without consulting the table. Its resolution never changes the table.

The table depth is a parameter. A depth of one makes every branch share a single counter.

Top module: `bhp_predictor`

## Requirements
- R1: While reset is asserted, and directly after it, every counter is in state WNT (2'b01). All lookups then predict not taken.
- R2: The entry index is PC bits [2 +: log2(DEPTH)]. With the default DEPTH of 512 this is PC[10:2]. Two PCs that differ only above that field share one counter. With DEPTH = 1 all PCs share a single counter. DEPTH must be a power of two.
- R3: A qualifying update with outcome taken moves the selected counter up one state: SNT to WNT, WNT to WT, WT to ST.
- R4: A qualifying update with outcome not taken moves the selected counter down one state: ST to WT, WT to WNT, WNT to SNT.
- R5: Counters saturate. A taken update leaves ST at ST, and a not-taken update leaves SNT at SNT.
- R6: For a lookup without a hint, `lk_taken` is the counter's upper bit. SNT and WNT predict not taken (0); WT and ST predict taken (1).
- R7: A lookup with `lk_hint` = 1 returns `lk_taken` = 1 whatever the counter holds.
- R8: An update with `up_hint` = 1 leaves every counter unchanged.
- R9: Counters change only on a clock edge at which `up_valid` = 1. With `up_valid` = 0, `up_pc` and `up_taken` have no effect.
- R10: When a lookup and an update select the same entry in the same cycle, the lookup returns the prediction of the counter value from before the update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; counters change on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_pc | input | PC_W | PC of the branch being predicted |
| lk_hint | input | 1 | Static likely-taken hint for the looked-up branch |
| lk_taken | output | 1 | Prediction: 1 = taken |
| up_valid | input | 1 | Update strobe for a resolved branch |
| up_pc | input | PC_W | PC of the resolved branch |
| up_hint | input | 1 | Resolved branch carried the static hint |
| up_taken | input | 1 | Actual outcome: 1 = taken |

## Verification
A counter sitting in the wrong state shows at the ports only through `lk_taken`, and only when that entry is looked up. A fault between two states that give the same prediction (SNT against WNT, or WT against ST) stays hidden until a later update pushes the entry across the midpoint. The tests therefore drive the counters through full up and down sweeps and read the entry back after every step. That exposes a bad transition within one or two updates. Aliasing faults and index faults show up on the first lookup of a PC that should or should not share an entry.

// File: rtl/bhp_pkg.sv
package bhp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_state_t;

    localparam ctr_state_t CTR_RESET = CTR_WNT;

    // Index width for a table of the given depth (at least one bit).
    function automatic int idx_width(input int depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction

endpackage

// File: rtl/bhp_index.sv
module bhp_index #(
    parameter int PC_W  = 32,
    parameter int DEPTH = 512,
    parameter int IDX_W = 9
) (
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] idx
);
    localparam int LSB = 2;

    generate
        if (DEPTH == 1) begin : g_single
            assign idx = '0;
        end else begin : g_multi
            assign idx = pc[LSB +: IDX_W];
        end
    endgenerate

endmodule

// File: rtl/bhp_ctr_fsm.sv
module bhp_ctr_fsm
    import bhp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step_en,
    input  logic       step_taken,
    output logic [1:0] state_o,
    output logic       pred_o
);
    ctr_state_t state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (step_en) begin
            unique case (state_q)
                CTR_SNT: state_d = step_taken ? CTR_WNT : CTR_SNT;
                CTR_WNT: state_d = step_taken ? CTR_WT  : CTR_SNT;
                CTR_WT:  state_d = step_taken ? CTR_ST  : CTR_WNT;
                CTR_ST:  state_d = step_taken ? CTR_ST  : CTR_WT;
                default: state_d = CTR_RESET;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTR_RESET;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CTR_SNT, CTR_WNT: pred_o = 1'b0;
            CTR_WT,  CTR_ST:  pred_o = 1'b1;
            default:          pred_o = 1'b0;
        endcase
        state_o = state_q;
    end

endmodule

// File: rtl/bhp_predictor.sv
module bhp_predictor
    import bhp_pkg::*;
#(
    parameter int PC_W  = 32,
    parameter int DEPTH = 512
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] lk_pc,
    input  logic            lk_hint,
    output logic            lk_taken,
    input  logic            up_valid,
    input  logic [PC_W-1:0] up_pc,
    input  logic            up_hint,
    input  logic            up_taken
);
    localparam int IDX_W = idx_width(DEPTH);

    generate
        if ((DEPTH < 1) || ((DEPTH & (DEPTH - 1)) != 0)) begin : g_bad_depth
            $error("bhp_predictor: DEPTH must be a power of two");
        end
    endgenerate

    logic [IDX_W-1:0]   lk_idx;
    logic [IDX_W-1:0]   up_idx;
    logic [DEPTH-1:0]   pred_vec;
    logic [2*DEPTH-1:0] ctr_flat;
    logic               up_write;

    bhp_index #(.PC_W(PC_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_lk_index (
        .pc  (lk_pc),
        .idx (lk_idx)
    );

    bhp_index #(.PC_W(PC_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) u_up_index (
        .pc  (up_pc),
        .idx (up_idx)
    );

    // Hinted branches never touch the table.
    assign up_write = up_valid & ~up_hint;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_entry
            logic sel;
            assign sel = up_write && (up_idx == IDX_W'(i));
            bhp_ctr_fsm u_ctr (
                .clk        (clk),
                .rst_n      (rst_n),
                .step_en    (sel),
                .step_taken (up_taken),
                .state_o    (ctr_flat[2*i +: 2]),
                .pred_o     (pred_vec[i])
            );
        end
    endgenerate

    // prediction output
    always_comb begin
        if (lk_hint) lk_taken = 1'b1;
        else         lk_taken = pred_vec[lk_idx];
    end

endmodule

// File: rtl/bhp_predictor_chk.sv
module bhp_predictor_chk
    import bhp_pkg::*;
#(
    parameter int DEPTH = 512,
    parameter int IDX_W = 9
) (
    input logic               clk,
    input logic               rst_n,
    input logic               lk_hint,
    input logic               lk_taken,
    input logic               up_valid,
    input logic               up_hint,
    input logic               up_taken,
    input logic [IDX_W-1:0]   up_idx,
    input logic [2*DEPTH-1:0] ctr_flat
);
    logic wr;
    assign wr = up_valid && !up_hint;

    // R1
    a_r1_reset_state: assert property (@(posedge clk)
        !rst_n |=> (ctr_flat == {DEPTH{2'b01}}));

    // R7
    a_r7_hint_taken: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hint |-> lk_taken);

    // R8 / R9
    a_r9_no_write_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ctr_flat));

    // R3
    a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && up_taken && ctr_flat[2*up_idx +: 2] != 2'b11) |=>
        (ctr_flat[2*$past(up_idx) +: 2] == $past(ctr_flat[2*up_idx +: 2]) + 2'b01));

    // R4
    a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !up_taken && ctr_flat[2*up_idx +: 2] != 2'b00) |=>
        (ctr_flat[2*$past(up_idx) +: 2] == $past(ctr_flat[2*up_idx +: 2]) - 2'b01));

    // R5
    a_r5_sat_top: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && up_taken && ctr_flat[2*up_idx +: 2] == 2'b11) |=>
        (ctr_flat[2*$past(up_idx) +: 2] == 2'b11));

    a_r5_sat_bottom: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && !up_taken && ctr_flat[2*up_idx +: 2] == 2'b00) |=>
        (ctr_flat[2*$past(up_idx) +: 2] == 2'b00));

endmodule

bind bhp_predictor bhp_predictor_chk #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .lk_hint  (lk_hint),
    .lk_taken (lk_taken),
    .up_valid (up_valid),
    .up_hint  (up_hint),
    .up_taken (up_taken),
    .up_idx   (up_idx),
    .ctr_flat (ctr_flat)
);

// File: tb/bhp_predictor_tb.sv
module bhp_predictor_tb;
    localparam int PC_W = 32;
    localparam logic [31:0] PA = 32'h0000_2008; // index 2
    localparam logic [31:0] PB = 32'h0000_2808; // aliases PA (bit 11 differs)
    localparam logic [31:0] PC = 32'h0000_200C; // index 3
    localparam int NV = 17;

    // {up_valid, up_hint, up_taken, up_pc, lk_pc, lk_hint, expected}
    localparam logic [68:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b0, PA, PA, 1'b0, 1'b0}, // 0  R1 WNT
        {1'b1, 1'b0, 1'b1, PA, PA, 1'b0, 1'b0}, // 1  R10 pre-update; A->WT
        {1'b0, 1'b0, 1'b0, PA, PA, 1'b0, 1'b1}, // 2  R3 WT taken
        {1'b1, 1'b0, 1'b1, PA, PB, 1'b0, 1'b1}, // 3  R2 alias; A->ST
        {1'b1, 1'b0, 1'b1, PA, PC, 1'b0, 1'b0}, // 4  R2 other idx; A stays ST
        {1'b1, 1'b0, 1'b0, PA, PA, 1'b0, 1'b1}, // 5  R5 ST; A->WT
        {1'b1, 1'b0, 1'b0, PA, PA, 1'b0, 1'b1}, // 6  R4 WT; A->WNT
        {1'b1, 1'b0, 1'b0, PA, PA, 1'b0, 1'b0}, // 7  R4 WNT; A->SNT
        {1'b1, 1'b0, 1'b0, PA, PA, 1'b0, 1'b0}, // 8  R5 SNT stays
        {1'b1, 1'b0, 1'b1, PA, PA, 1'b0, 1'b0}, // 9  R5 SNT; A->WNT
        {1'b0, 1'b0, 1'b0, PA, PA, 1'b0, 1'b0}, // 10 R5 WNT after one step
        {1'b1, 1'b1, 1'b1, PA, PA, 1'b0, 1'b0}, // 11 R8 hinted update
        {1'b0, 1'b0, 1'b0, PA, PA, 1'b1, 1'b1}, // 12 R7 hinted lookup
        {1'b0, 1'b0, 1'b1, PA, PA, 1'b0, 1'b0}, // 13 R8/R9 still WNT; invalid update
        {1'b0, 1'b0, 1'b0, PA, PA, 1'b0, 1'b0}, // 14 R9 still WNT
        {1'b1, 1'b0, 1'b1, PC, PC, 1'b0, 1'b0}, // 15 R10 C WNT->WT
        {1'b0, 1'b0, 1'b0, PC, PC, 1'b0, 1'b1}  // 16 R6 C WT predicts taken
    };
    localparam string TAG [NV] = '{"R1", "R10", "R3", "R2", "R2", "R5", "R4", "R4",
                                   "R5", "R5", "R5", "R8", "R7", "R8", "R9", "R10", "R6"};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [PC_W-1:0] lk_pc = '0, up_pc = '0;
    logic lk_hint = 1'b0, up_valid = 1'b0, up_hint = 1'b0, up_taken = 1'b0;
    logic lk_taken;

    logic [PC_W-1:0] s_lk_pc = '0, s_up_pc = '0;
    logic s_up_valid = 1'b0, s_up_taken = 1'b0;
    logic s_lk_taken;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    bhp_predictor #(.PC_W(PC_W), .DEPTH(512)) u_dut (
        .clk(clk), .rst_n(rst_n), .lk_pc(lk_pc), .lk_hint(lk_hint), .lk_taken(lk_taken),
        .up_valid(up_valid), .up_pc(up_pc), .up_hint(up_hint), .up_taken(up_taken)
    );

    bhp_predictor #(.PC_W(PC_W), .DEPTH(1)) u_dut1 (
        .clk(clk), .rst_n(rst_n), .lk_pc(s_lk_pc), .lk_hint(1'b0), .lk_taken(s_lk_taken),
        .up_valid(s_up_valid), .up_pc(s_up_pc), .up_hint(1'b0), .up_taken(s_up_taken)
    );

    task automatic check(input string req, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: lk_taken actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic idle_inputs();
        up_valid = 1'b0; up_hint = 1'b0; up_taken = 1'b0; lk_hint = 1'b0;
        s_up_valid = 1'b0; s_up_taken = 1'b0;
    endtask

    initial begin
        idle_inputs();
        repeat (3) @(negedge clk);
        #5;
        check("R1", lk_taken, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            @(negedge clk);
            {up_valid, up_hint, up_taken, up_pc, lk_pc, lk_hint} = VEC[i][68:1];
            #5;
            check(TAG[i], lk_taken, VEC[i][0]);
        end
        @(negedge clk);
        idle_inputs();

        // R2: single-entry table, updates on one PC steer every PC
        s_up_pc = 32'h0000_0100; s_up_taken = 1'b1; s_up_valid = 1'b1;
        s_lk_pc = 32'h0000_2000;
        @(negedge clk);
        @(negedge clk);
        s_up_valid = 1'b0;
        #5;
        check("R2", s_lk_taken, 1'b1);
        s_lk_pc = 32'h0000_0004;
        #1;
        check("R2", s_lk_taken, 1'b1);

        // R2: highest index entry is independent of entry 2
        lk_pc = 32'h0000_07FC; up_pc = 32'h0000_07FC; up_taken = 1'b1; up_valid = 1'b1;
        @(negedge clk);
        up_valid = 1'b0;
        #5;
        check("R2", lk_taken, 1'b1);
        lk_pc = PA;
        #1;
        check("R2", lk_taken, 1'b0);

        // R1: reset returns every entry to WNT
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        lk_pc = 32'h0000_07FC;
        #5;
        check("R1", lk_taken, 1'b0);
        s_lk_pc = 32'h0;
        #1;
        check("R1", s_lk_taken, 1'b0);
        lk_pc = PC;
        #1;
        check("R1", lk_taken, 1'b0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule